// File: doc/BRIEF.md
# Segment Descriptor Load Checker

This block services one segment-register load at a time. A request names an entry index in a descriptor table held in memory, the privilege level of the requester and the intended use of the segment (execute, read or write). The block first screens the index. Index zero is a null selector, and any index whose 8-byte entry would run past the table end is refused. If the index is good, the block fetches the entry as two 32-bit words and decodes the base, the 20-bit limit, the flag nibble and the access byte. It then applies the type and privilege rules.

When every rule passes, a hidden cache register takes the decoded base, the effective byte limit and the attributes, and `done` pulses. When a rule fails, `fault` pulses with a code and the cache keeps its previous contents. The table location comes from a base input and a size input, where size is the table length in bytes minus one.

Top module: `seg_desc_loader`

## Requirements
- R1: After reset, `busy`, `done`, `fault`, `mem_rd_req` and `cache_valid` are all low.
- R2: An index whose entry would run past the table end faults with `fault_code` 1 (general protection) and performs no memory read. "Past the end" means that index*8+7 is greater than `tbl_size`. The highest index that fits still loads.
- R3: Index 0 is a null selector and issues no memory read. For read or write use it pulses `done` and clears `cache_valid`. For execute use it faults with code 1.
- R4: The entry is fetched as two reads. The low word comes first, at `tbl_base`+8*index, and the high word follows at that address +4. Each read holds `mem_rd_req` and its address until `mem_rd_valid` is high.
- R5: The low word carries limit[15:0] in bits 15:0 and base[15:0] in bits 31:16. The high word carries base[23:16] in bits 7:0, the access byte in bits 15:8, limit[19:16] in bits 19:16, the flag nibble in bits 23:20 (bit 23 is granularity) and base[31:24] in bits 31:24. With granularity set, the effective limit is (limit<<12)|0xFFF. `cache_attr` holds {flags, access byte}.
- R6: For a conforming code segment (access bit 4 set, bit 3 set, bit 2 set), the load passes the privilege check when the requester level is numerically greater than or equal to the descriptor level, which is access bits 6:5.
- R7: For a non-conforming code segment (access bit 2 clear), the requester level must equal the descriptor level, otherwise the load faults with code 1.
- R8: A code segment can never be loaded for write. It can be loaded for read only when access bit 1 (readable) is set. Use is encoded as 0 execute, 1 read, 2 write.
- R9: A data segment (access bit 3 clear) faults for execute use. It faults for write use when access bit 1 (writable) is clear. It faults when its descriptor level is numerically lower than the requester level. An entry with access bit 4 clear (system type) always faults with code 1.
- R10: An entry with the present bit (access bit 7) clear faults with `fault_code` 2. This check is made only after all code-1 checks have passed.
- R11: The cache register is written only when the load succeeds. After a fault, its valid bit, base, limit and attributes are unchanged.
- R12: A request is accepted only while idle. `busy` stays high from acceptance through the cycle of the single-cycle `done` or `fault` pulse. `done` and `fault` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_base | input | 32 | Linear address of the descriptor table |
| tbl_size | input | 16 | Table length in bytes minus one |
| req_valid | input | 1 | Load request strobe, taken while idle |
| req_index | input | 13 | Table entry index |
| req_cpl | input | 2 | Requester privilege level |
| req_use | input | 2 | Intended use: 0 execute, 1 read, 2 write |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle success pulse |
| fault | output | 1 | One-cycle refusal pulse |
| fault_code | output | 2 | 0 none, 1 general protection, 2 not present |
| mem_rd_req | output | 1 | Memory read request |
| mem_rd_addr | output | 32 | Memory read byte address |
| mem_rd_valid | input | 1 | Read data valid this cycle |
| mem_rd_data | input | 32 | Read data word |
| cache_valid | output | 1 | Cached descriptor is usable |
| cache_base | output | 32 | Cached segment base |
| cache_limit | output | 32 | Cached effective byte limit |
| cache_attr | output | 12 | Cached flag nibble and access byte |

## Verification
The bench checks the exact table-end boundary with a size one byte short of the last entry. An off-by-one compare there would either load an entry that is partly outside the table or refuse the last legal one. It drives requesters at a higher, equal and lower level against conforming and non-conforming code, where swapped or mixed rules show up as wrong pass/fault outcomes. It also checks an absent data entry loaded for execute: a design that tests presence first would report code 2 instead of 1. Finally, it checks that the cache survives each fault unchanged, that null loads make no memory access, and that a request arriving while busy is dropped and not queued.

// File: rtl/seg_ld_pkg.sv
package seg_ld_pkg;

  typedef enum logic [1:0] {
    USE_EXEC  = 2'd0,
    USE_READ  = 2'd1,
    USE_WRITE = 2'd2
  } use_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK_INDEX,
    ST_READ_LO,
    ST_READ_HI,
    ST_CHECK_ACCESS,
    ST_DONE,
    ST_FAULT
  } ld_state_e;

  localparam logic [1:0] FC_NONE = 2'd0;
  localparam logic [1:0] FC_GP   = 2'd1;
  localparam logic [1:0] FC_NP   = 2'd2;

  localparam int WORD_W      = 32;
  localparam int ENTRY_SHIFT = 3;
  localparam int LIM_W       = 20;
  localparam int ACC_W       = 8;
  localparam int FLAG_W      = 4;
  localparam int ATTR_W      = FLAG_W + ACC_W;

endpackage

// File: rtl/seg_idx_check.sv
module seg_idx_check #(
  parameter int IDX_W  = 13,
  parameter int SIZE_W = 16
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic              is_null_o,
  output logic              out_of_range_o
);
  import seg_ld_pkg::*;

  localparam int END_W = IDX_W + ENTRY_SHIFT;
  localparam int CMP_W = ((END_W > SIZE_W) ? END_W : SIZE_W) + 1;

  logic [CMP_W-1:0] last_byte;
  logic [CMP_W-1:0] size_ext;

  // Last byte of the entry: index*8 + 7.
  assign last_byte = CMP_W'({idx_i, {ENTRY_SHIFT{1'b1}}});
  assign size_ext  = CMP_W'(size_i);

  assign is_null_o      = (idx_i == '0);
  assign out_of_range_o = (last_byte > size_ext);

endmodule

// File: rtl/seg_desc_decode.sv
module seg_desc_decode #(
  parameter int PAGE_SHIFT = 12
) (
  input  logic [31:0]                  lo_i,
  input  logic [31:0]                  hi_i,
  output logic [31:0]                  base_o,
  output logic [31:0]                  limit_o,
  output logic [seg_ld_pkg::ATTR_W-1:0] attr_o,
  output logic                         present_o,
  output logic [1:0]                   dpl_o,
  output logic                         is_seg_o,
  output logic                         is_code_o,
  output logic                         dc_o,
  output logic                         rw_o
);
  import seg_ld_pkg::*;

  logic [LIM_W-1:0]  raw_limit;
  logic [ACC_W-1:0]  acc;
  logic [FLAG_W-1:0] flags;
  logic              gran;
  logic [31:0]       lim_ext;

  assign raw_limit = {hi_i[19:16], lo_i[15:0]};
  assign acc       = hi_i[15:8];
  assign flags     = hi_i[23:20];
  assign gran      = flags[FLAG_W-1];

  assign base_o  = {hi_i[31:24], hi_i[7:0], lo_i[31:16]};
  assign lim_ext = {{(32-LIM_W){1'b0}}, raw_limit};

  // Page-granular limits fill the low PAGE_SHIFT bits with ones.
  always_comb begin
    if (gran) limit_o = (lim_ext << PAGE_SHIFT) | ((32'd1 << PAGE_SHIFT) - 32'd1);
    else      limit_o = lim_ext;
  end

  assign attr_o    = {flags, acc};
  assign present_o = acc[7];
  assign dpl_o     = acc[6:5];
  assign is_seg_o  = acc[4];
  assign is_code_o = acc[3];
  assign dc_o      = acc[2];
  assign rw_o      = acc[1];

endmodule

// File: rtl/seg_access_rules.sv
module seg_access_rules (
  input  logic [1:0] cpl_i,
  input  logic [1:0] use_i,
  input  logic       present_i,
  input  logic [1:0] dpl_i,
  input  logic       is_seg_i,
  input  logic       is_code_i,
  input  logic       dc_i,
  input  logic       rw_i,
  output logic       gp_o,
  output logic       np_o
);
  import seg_ld_pkg::*;

  logic use_bad;
  logic priv_bad;

  always_comb begin
    use_bad  = 1'b0;
    priv_bad = 1'b0;
    if (is_code_i) begin
      unique case (use_i)
        USE_EXEC: use_bad = 1'b0;
        USE_READ: use_bad = !rw_i;
        default:  use_bad = 1'b1;
      endcase
      if (dc_i) priv_bad = (cpl_i < dpl_i);
      else      priv_bad = (cpl_i != dpl_i);
    end else begin
      unique case (use_i)
        USE_EXEC: use_bad = 1'b1;
        USE_READ: use_bad = 1'b0;
        default:  use_bad = !rw_i;
      endcase
      priv_bad = (dpl_i < cpl_i);
    end
  end

  // Protection problems take precedence over absence.
  assign gp_o = !is_seg_i || use_bad || priv_bad;
  assign np_o = !gp_o && !present_i;

endmodule

// File: rtl/seg_desc_loader.sv
module seg_desc_loader #(
  parameter int IDX_W  = 13,
  parameter int SIZE_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [31:0]                   tbl_base,
  input  logic [SIZE_W-1:0]             tbl_size,
  input  logic                          req_valid,
  input  logic [IDX_W-1:0]              req_index,
  input  logic [1:0]                    req_cpl,
  input  logic [1:0]                    req_use,
  output logic                          busy,
  output logic                          done,
  output logic                          fault,
  output logic [1:0]                    fault_code,
  output logic                          mem_rd_req,
  output logic [31:0]                   mem_rd_addr,
  input  logic                          mem_rd_valid,
  input  logic [31:0]                   mem_rd_data,
  output logic                          cache_valid,
  output logic [31:0]                   cache_base,
  output logic [31:0]                   cache_limit,
  output logic [seg_ld_pkg::ATTR_W-1:0] cache_attr
);
  import seg_ld_pkg::*;

  localparam int OFS_W = IDX_W + ENTRY_SHIFT;

  ld_state_e         state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [1:0]        cpl_q, cpl_d;
  logic [1:0]        use_q, use_d;
  logic [31:0]       tb_q, tb_d;
  logic [31:0]       lo_q, lo_d;
  logic [31:0]       hi_q, hi_d;
  logic [1:0]        fc_q, fc_d;
  logic              cv_q, cv_d;
  logic [31:0]       cb_q, cb_d;
  logic [31:0]       cl_q, cl_d;
  logic [ATTR_W-1:0] ca_q, ca_d;

  logic              idx_null, idx_oor;
  logic [31:0]       dec_base, dec_limit;
  logic [ATTR_W-1:0] dec_attr;
  logic              dec_present, dec_seg, dec_code, dec_dc, dec_rw;
  logic [1:0]        dec_dpl;
  logic              rule_gp, rule_np;
  logic [OFS_W-1:0]  entry_ofs;

  seg_idx_check #(.IDX_W(IDX_W), .SIZE_W(SIZE_W)) u_idx (
    .idx_i          (idx_q),
    .size_i         (tbl_size),
    .is_null_o      (idx_null),
    .out_of_range_o (idx_oor)
  );

  seg_desc_decode #(.PAGE_SHIFT(12)) u_dec (
    .lo_i      (lo_q),
    .hi_i      (hi_q),
    .base_o    (dec_base),
    .limit_o   (dec_limit),
    .attr_o    (dec_attr),
    .present_o (dec_present),
    .dpl_o     (dec_dpl),
    .is_seg_o  (dec_seg),
    .is_code_o (dec_code),
    .dc_o      (dec_dc),
    .rw_o      (dec_rw)
  );

  seg_access_rules u_rules (
    .cpl_i     (cpl_q),
    .use_i     (use_q),
    .present_i (dec_present),
    .dpl_i     (dec_dpl),
    .is_seg_i  (dec_seg),
    .is_code_i (dec_code),
    .dc_i      (dec_dc),
    .rw_i      (dec_rw),
    .gp_o      (rule_gp),
    .np_o      (rule_np)
  );

  // Next-state and data-path enables.
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    cpl_d   = cpl_q;
    use_d   = use_q;
    tb_d    = tb_q;
    lo_d    = lo_q;
    hi_d    = hi_q;
    fc_d    = fc_q;
    cv_d    = cv_q;
    cb_d    = cb_q;
    cl_d    = cl_q;
    ca_d    = ca_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          idx_d   = req_index;
          cpl_d   = req_cpl;
          use_d   = req_use;
          tb_d    = tbl_base;
          state_d = ST_CHECK_INDEX;
        end
      end
      ST_CHECK_INDEX: begin
        if (idx_null) begin
          if (use_q == USE_EXEC) begin
            fc_d    = FC_GP;
            state_d = ST_FAULT;
          end else begin
            cv_d    = 1'b0;
            fc_d    = FC_NONE;
            state_d = ST_DONE;
          end
        end else if (idx_oor) begin
          fc_d    = FC_GP;
          state_d = ST_FAULT;
        end else begin
          state_d = ST_READ_LO;
        end
      end
      ST_READ_LO: begin
        if (mem_rd_valid) begin
          lo_d    = mem_rd_data;
          state_d = ST_READ_HI;
        end
      end
      ST_READ_HI: begin
        if (mem_rd_valid) begin
          hi_d    = mem_rd_data;
          state_d = ST_CHECK_ACCESS;
        end
      end
      ST_CHECK_ACCESS: begin
        if (rule_gp) begin
          fc_d    = FC_GP;
          state_d = ST_FAULT;
        end else if (rule_np) begin
          fc_d    = FC_NP;
          state_d = ST_FAULT;
        end else begin
          cv_d    = 1'b1;
          cb_d    = dec_base;
          cl_d    = dec_limit;
          ca_d    = dec_attr;
          fc_d    = FC_NONE;
          state_d = ST_DONE;
        end
      end
      ST_DONE:  state_d = ST_IDLE;
      ST_FAULT: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // Register process.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cpl_q   <= '0;
      use_q   <= '0;
      tb_q    <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      fc_q    <= FC_NONE;
      cv_q    <= 1'b0;
      cb_q    <= '0;
      cl_q    <= '0;
      ca_q    <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      cpl_q   <= cpl_d;
      use_q   <= use_d;
      tb_q    <= tb_d;
      lo_q    <= lo_d;
      hi_q    <= hi_d;
      fc_q    <= fc_d;
      cv_q    <= cv_d;
      cb_q    <= cb_d;
      cl_q    <= cl_d;
      ca_q    <= ca_d;
    end
  end

  assign entry_ofs = {idx_q, {ENTRY_SHIFT{1'b0}}};

  assign busy        = (state_q != ST_IDLE);
  assign done        = (state_q == ST_DONE);
  assign fault       = (state_q == ST_FAULT);
  assign fault_code  = fc_q;
  assign mem_rd_req  = (state_q == ST_READ_LO) || (state_q == ST_READ_HI);
  assign mem_rd_addr = tb_q + 32'(entry_ofs) + ((state_q == ST_READ_HI) ? 32'd4 : 32'd0);
  assign cache_valid = cv_q;
  assign cache_base  = cb_q;
  assign cache_limit = cl_q;
  assign cache_attr  = ca_q;

endmodule

// File: rtl/seg_desc_loader_chk.sv
module seg_desc_loader_chk (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          busy,
  input logic                          done,
  input logic                          fault,
  input logic [1:0]                    fault_code,
  input logic                          mem_rd_req,
  input logic                          mem_rd_valid,
  input logic [31:0]                   mem_rd_addr,
  input logic                          cache_valid,
  input logic [31:0]                   cache_base,
  input logic [31:0]                   cache_limit,
  input logic [seg_ld_pkg::ATTR_W-1:0] cache_attr
);

  assert_pulse_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));

  assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |=> !(done || fault));

  assert_busy_at_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |-> busy);

  assert_fault_coded_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (fault_code == 2'd1 || fault_code == 2'd2));

  assert_read_in_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> busy);

  assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && $past(mem_rd_req) && !$past(mem_rd_valid)) |-> $stable(mem_rd_addr));

  assert_cache_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(cache_valid) && $stable(cache_base) &&
               $stable(cache_limit) && $stable(cache_attr)));

  assert_cached_present_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cache_valid) |-> cache_attr[7]);

endmodule

bind seg_desc_loader seg_desc_loader_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .done         (done),
  .fault        (fault),
  .fault_code   (fault_code),
  .mem_rd_req   (mem_rd_req),
  .mem_rd_valid (mem_rd_valid),
  .mem_rd_addr  (mem_rd_addr),
  .cache_valid  (cache_valid),
  .cache_base   (cache_base),
  .cache_limit  (cache_limit),
  .cache_attr   (cache_attr)
);

// File: tb/seg_desc_loader_tb_top.sv
module seg_desc_loader_tb_top;

  logic        clk;
  logic        rst_n;
  logic [31:0] tbl_base;
  logic [15:0] tbl_size;
  logic        req_valid;
  logic [12:0] req_index;
  logic [1:0]  req_cpl;
  logic [1:0]  req_use;
  logic        busy, done, fault;
  logic [1:0]  fault_code;
  logic        mem_rd_req;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_valid;
  logic [31:0] mem_rd_data;
  logic        cache_valid;
  logic [31:0] cache_base, cache_limit;
  logic [11:0] cache_attr;

  int checks = 0;
  int errors = 0;
  int reads  = 0;
  bit finished = 0;
  logic [31:0] last_lo_addr, last_hi_addr;
  logic [63:0] desc_mem [0:15];

  seg_desc_loader dut_i (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Memory with one cycle of latency per word.
  always @(posedge clk) begin
    if (mem_rd_req && mem_rd_valid) begin
      reads <= reads + 1;
      if (mem_rd_addr[2]) last_hi_addr <= mem_rd_addr;
      else                last_lo_addr <= mem_rd_addr;
    end
    if (mem_rd_req && !mem_rd_valid) begin
      mem_rd_valid <= 1'b1;
      if (mem_rd_addr >= 32'h1000 && mem_rd_addr < 32'h1080)
        mem_rd_data <= mem_rd_addr[2] ? desc_mem[mem_rd_addr[6:3]][63:32]
                                      : desc_mem[mem_rd_addr[6:3]][31:0];
      else
        mem_rd_data <= 32'h0;
    end else begin
      mem_rd_valid <= 1'b0;
    end
  end

  function automatic logic [63:0] mk(input logic [31:0] b, input logic [19:0] l,
                                     input logic [7:0] acc, input logic [3:0] fl);
    return {b[31:24], fl, l[19:16], acc, b[23:16], b[15:0], l[15:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  bit       r_done, r_fault;
  logic [1:0] r_code;

  task automatic run(input logic [12:0] idx, input logic [1:0] cpl, input logic [1:0] use_v);
    int n;
    @(negedge clk);
    req_valid = 1'b1; req_index = idx; req_cpl = cpl; req_use = use_v;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!(done || fault) && n < 100) begin
      @(negedge clk);
      n++;
    end
    r_done = done; r_fault = fault; r_code = fault_code;
  endtask

  // {idx, cpl, use, code, base, limit}; use 0 exec 1 read 2 write; code 0 ok 1 GP 2 NP
  localparam logic [82:0] VECS [0:15] = '{
    {13'd1, 2'd0, 2'd0, 2'd0, 32'h00400000, 32'h0000FFFF}, // R7 equal level
    {13'd1, 2'd3, 2'd0, 2'd1, 32'h0, 32'h0},               // R7 mismatch
    {13'd2, 2'd3, 2'd0, 2'd0, 32'h12345678, 32'h00ABCFFF}, // R6 higher number
    {13'd2, 2'd1, 2'd0, 2'd1, 32'h0, 32'h0},               // R6 lower number
    {13'd2, 2'd2, 2'd1, 2'd1, 32'h0, 32'h0},               // R8 exec-only read
    {13'd1, 2'd0, 2'd1, 2'd0, 32'h00400000, 32'h0000FFFF}, // R8 readable code
    {13'd1, 2'd0, 2'd2, 2'd1, 32'h0, 32'h0},               // R8 code write
    {13'd3, 2'd3, 2'd2, 2'd0, 32'h80000000, 32'hFFFFFFFF}, // R5 R9 full span
    {13'd4, 2'd1, 2'd2, 2'd1, 32'h0, 32'h0},               // R9 read-only write
    {13'd4, 2'd0, 2'd1, 2'd0, 32'h0000A000, 32'h00000123}, // R9 R5 byte limit
    {13'd4, 2'd2, 2'd1, 2'd1, 32'h0, 32'h0},               // R9 level too low
    {13'd5, 2'd3, 2'd2, 2'd2, 32'h0, 32'h0},               // R10 absent
    {13'd6, 2'd0, 2'd1, 2'd1, 32'h0, 32'h0},               // R9 system type
    {13'd8, 2'd0, 2'd1, 2'd1, 32'h0, 32'h0},               // R2 beyond table
    {13'd3, 2'd0, 2'd0, 2'd1, 32'h0, 32'h0},               // R9 data exec
    {13'd7, 2'd3, 2'd0, 2'd0, 32'h00000100, 32'h00000010}  // R7 level 3
  };

  initial begin
    logic        ecv;
    logic [31:0] eb, el;
    int          rd0;
    for (int i = 0; i < 16; i++) desc_mem[i] = 64'h0;
    desc_mem[1] = mk(32'h00400000, 20'h0FFFF, 8'h9A, 4'h4);
    desc_mem[2] = mk(32'h12345678, 20'h00ABC, 8'hDC, 4'hC);
    desc_mem[3] = mk(32'h80000000, 20'hFFFFF, 8'hF2, 4'h8);
    desc_mem[4] = mk(32'h0000A000, 20'h00123, 8'hB0, 4'h4);
    desc_mem[5] = mk(32'h00005000, 20'h00FFF, 8'h72, 4'h4);
    desc_mem[6] = mk(32'h00006000, 20'h00FFF, 8'h89, 4'h0);
    desc_mem[7] = mk(32'h00000100, 20'h00010, 8'hF8, 4'h4);
    tbl_base = 32'h1000; tbl_size = 16'd63;
    req_valid = 0; req_index = 0; req_cpl = 0; req_use = 0;
    mem_rd_valid = 0; mem_rd_data = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fault && !mem_rd_req && !cache_valid, "R1 reset outputs",
        {busy, done, fault, mem_rd_req, cache_valid}, 0);
    rst_n = 1;
    @(negedge clk);

    ecv = 0; eb = 0; el = 0;
    for (int v = 0; v < 16; v++) begin
      logic [82:0] t;
      t = VECS[v];
      rd0 = reads;
      run(t[82:70], t[69:68], t[67:66]);
      if (t[65:64] == 2'd0) begin
        ecv = 1; eb = t[63:32]; el = t[31:0];
        chk(r_done && !r_fault, "R6 R7 R8 R9 success pulse", {r_done, r_fault}, 2'b10);
      end else begin
        chk(r_fault && !r_done && r_code == t[65:64], "R2 R6 R7 R8 R9 R10 fault code",
            {r_fault, r_code}, {1'b1, t[65:64]});
      end
      chk(cache_valid == ecv && cache_base == eb && cache_limit == el, "R5 R11 cache",
          {cache_valid, cache_base, cache_limit}, {ecv, eb, el});
      if (t[82:70] == 13'd8)
        chk(reads == rd0, "R2 no read past end", reads - rd0, 0);
      @(negedge clk);
      chk(!done && !fault && !busy, "R12 single pulse", {done, fault, busy}, 0);
    end

    // R5 attributes and R4 addresses of a fresh load
    run(13'd3, 2'd3, 2'd1);
    chk(cache_attr == 12'h8F2, "R5 cache_attr", cache_attr, 12'h8F2);
    chk(last_lo_addr == 32'h1018 && last_hi_addr == 32'h101C, "R4 fetch addresses",
        {last_lo_addr, last_hi_addr}, {32'h1018, 32'h101C});

    // R10 ordering: absent data entry used for execute reports GP
    run(13'd5, 2'd3, 2'd0);
    chk(r_fault && r_code == 2'd1, "R10 GP before NP", r_code, 1);

    // R3 null selector
    rd0 = reads;
    run(13'd0, 2'd0, 2'd1);
    chk(r_done && !cache_valid && reads == rd0, "R3 null data load",
        {r_done, cache_valid, 32'(reads - rd0)}, {1'b1, 1'b0, 32'd0});
    run(13'd0, 2'd0, 2'd0);
    chk(r_fault && r_code == 2'd1 && !cache_valid, "R3 null code load",
        {r_fault, r_code}, 3'b101);

    // R2 boundary: the last entry fits at size 63, not at 62
    run(13'd7, 2'd3, 2'd0);
    chk(r_done && cache_limit == 32'h10, "R2 last entry fits", {r_done, cache_limit}, {1'b1, 32'h10});
    tbl_size = 16'd62;
    rd0 = reads;
    run(13'd7, 2'd3, 2'd0);
    chk(r_fault && r_code == 2'd1 && reads == rd0, "R2 one byte short",
        {r_fault, r_code, 32'(reads - rd0)}, {1'b1, 2'd1, 32'd0});
    chk(cache_valid && cache_limit == 32'h10, "R11 cache kept after fault",
        {cache_valid, cache_limit}, {1'b1, 32'h10});
    tbl_size = 16'd63;

    // R12 request while busy is dropped
    @(negedge clk);
    req_valid = 1; req_index = 13'd1; req_cpl = 2'd0; req_use = 2'd0;
    @(negedge clk);
    req_index = 13'd8; req_use = 2'd1;
    repeat (2) @(negedge clk);
    req_valid = 0;
    begin
      int n;
      n = 0;
      while (!(done || fault) && n < 100) begin @(negedge clk); n++; end
    end
    chk(done && cache_base == 32'h00400000, "R12 first request wins",
        {done, cache_base}, {1'b1, 32'h00400000});
    begin
      bit extra;
      extra = 0;
      repeat (8) begin @(negedge clk); if (done || fault || busy) extra = 1; end
      chk(!extra, "R12 busy request not queued", extra, 0);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R12 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule